// File: doc/BRIEF.md
# DMA-Fed Audio Output Sequencer

This block moves 10-bit audio samples from a DMA channel to a D/A converter at one of four conversion rates. A two-stage prefetch pipeline sits between the DMA port and the converter. A holding register takes each sample on DMA acknowledge. An output register feeds the converter on every conversion tick. Each stage has a valid flag, and both flags appear on ports. As soon as the holding stage empties, the block asks the DMA for the following sample. The pipeline therefore normally holds the next two samples ahead of the converter.

Conversion ticks come from a divider of the system clock. The divider runs only while output is enabled and the converter reference has been on for a settling time. If the output register is empty at a tick, the converter keeps its last sample and a mute interrupt is raised. The DMA side marks the last sample of a page. That marking raises a page interrupt and halts further requests until software clears it. Both interrupt bits are cleared by write-one pulses.

Top module: `audio_dma_out`

## Requirements
- R1: After reset, dma_req, hold_valid, out_valid, mute_irq, page_irq and dac_strobe are 0, and dac_data is 0.
- R2: While running, dac_strobe pulses once every D system clocks, where D is CLK_HZ/44100 for rate_sel 0, CLK_HZ/22050 for 1, CLK_HZ/11025 for 2 and CLK_HZ/8000 for 3 to 7. A new rate_sel takes effect at the next divider reload.
- R3: After out_en and vref_on are raised together, the first dac_strobe appears SETTLE_CYC + D clocks later, within one clock.
- R4: dma_req is high while out_en is 1, page_irq is 0 and the holding stage is empty. It is low in the cycle after an accepted dma_ack.
- R5: Once enabled, before the first tick, hold_valid and out_valid are both 1 and dma_req is 0, so two samples are prefetched.
- R6: At each dac_strobe with the output stage valid, dac_data presents the next sample, in acknowledge order.
- R7: At a dac_strobe with the output stage empty, dac_data is unchanged, mute_irq becomes 1, and dma_req stays high.
- R8: A dma_ack with dma_page_end=1 sets page_irq. While page_irq is 1, dma_req stays 0. After page_irq is cleared, requests resume.
- R9: A one-cycle pulse on mute_clr or page_clr clears the matching interrupt bit in the next cycle. A set event in the same cycle wins.
- R10: With out_en at 0, dma_req, hold_valid and out_valid are 0 one cycle later, and no dac_strobe occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| out_en | input | 1 | Output enable |
| rate_sel | input | 3 | Conversion rate select (0..7) |
| vref_on | input | 1 | Converter reference is powered |
| dma_req | output | 1 | Request for one sample |
| dma_ack | input | 1 | Sample on dma_data is delivered |
| dma_data | input | DW | Sample from DMA |
| dma_page_end | input | 1 | Delivered sample is the last of its page |
| mute_clr | input | 1 | Write-one pulse clearing mute_irq |
| page_clr | input | 1 | Write-one pulse clearing page_irq |
| dac_data | output | DW | Sample driven to the converter |
| dac_strobe | output | 1 | Conversion refresh pulse, aligned with dac_data |
| hold_valid | output | 1 | Holding stage is full |
| out_valid | output | 1 | Output stage is full |
| mute_irq | output | 1 | Underrun (mute) interrupt |
| page_irq | output | 1 | Page-boundary interrupt |

## Verification
The bench treats a tick as due SETTLE_CYC + D edges after enable, and every later tick exactly D edges after the one before. It counts edges at the falling clock and compares against those figures. dac_data, dac_strobe and the mute bit all change on the same edge. The scoreboard therefore compares the sample, or the underrun expectation, at the falling edge that follows the strobe. The DMA model answers a request half a cycle after it sees it, and checks that the request has dropped one edge after its acknowledge. Interrupt clears are checked one edge after the pulse, and the request gating one edge after the interrupt changes.

// File: rtl/audio_out_pkg.sv
package audio_out_pkg;
  typedef enum logic [1:0] {
    RATE_44K1   = 2'd0,
    RATE_22K05  = 2'd1,
    RATE_11K025 = 2'd2,
    RATE_8K     = 2'd3
  } rate_e;

  // Codes 3..7 all select the slowest rate.
  function automatic rate_e decode_rate(input logic [2:0] sel);
    case (sel)
      3'd0:    return RATE_44K1;
      3'd1:    return RATE_22K05;
      3'd2:    return RATE_11K025;
      default: return RATE_8K;
    endcase
  endfunction
endpackage

// File: rtl/audio_tick_gen.sv
module audio_tick_gen
  import audio_out_pkg::*;
#(
  parameter int unsigned CLK_HZ     = 100_000_000,
  parameter int unsigned SETTLE_CYC = 500
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       out_en,
  input  logic       vref_on,
  input  logic [2:0] rate_sel,
  output logic       tick
);
  localparam int unsigned DIV_A = CLK_HZ / 44100;
  localparam int unsigned DIV_B = CLK_HZ / 22050;
  localparam int unsigned DIV_C = CLK_HZ / 11025;
  localparam int unsigned DIV_D = CLK_HZ / 8000;
  localparam int unsigned CW    = $clog2(DIV_D + 1);
  localparam int unsigned SW    = $clog2(SETTLE_CYC + 1);

  logic [SW-1:0] settle_q;
  logic [CW-1:0] div_q;
  logic [CW-1:0] reload;
  logic          ready;
  logic          run;

  always_comb begin
    case (decode_rate(rate_sel))
      RATE_44K1:   reload = CW'(DIV_A - 1);
      RATE_22K05:  reload = CW'(DIV_B - 1);
      RATE_11K025: reload = CW'(DIV_C - 1);
      default:     reload = CW'(DIV_D - 1);
    endcase
  end

  assign ready = vref_on && (settle_q == SW'(SETTLE_CYC));
  assign run   = out_en && ready;
  assign tick  = run && (div_q == '0);

  always_ff @(posedge clk) begin
    if (rst || !vref_on) begin
      settle_q <= '0;
    end else if (settle_q != SW'(SETTLE_CYC)) begin
      settle_q <= settle_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      div_q <= reload;
    end else if (div_q == '0) begin
      div_q <= reload;
    end else begin
      div_q <= div_q - 1'b1;
    end
  end
endmodule

// File: rtl/audio_sample_pipe.sv
module audio_sample_pipe #(
  parameter int unsigned DW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          out_en,
  input  logic          tick,
  input  logic          stall,
  input  logic          dma_ack,
  input  logic [DW-1:0] dma_data,
  output logic          dma_req,
  output logic          hold_valid,
  output logic          out_valid,
  output logic [DW-1:0] dac_data,
  output logic          dac_strobe,
  output logic          underrun
);
  logic [DW-1:0] hold_q;
  logic [DW-1:0] out_q;
  logic          move;
  logic          hold_nx;

  assign move     = !out_valid && hold_valid;
  assign hold_nx  = dma_ack ? 1'b1 : (move ? 1'b0 : hold_valid);
  assign underrun = tick && !out_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q     <= '0;
      out_q      <= '0;
      dac_data   <= '0;
      hold_valid <= 1'b0;
      out_valid  <= 1'b0;
      dma_req    <= 1'b0;
      dac_strobe <= 1'b0;
    end else if (!out_en) begin
      hold_valid <= 1'b0;
      out_valid  <= 1'b0;
      dma_req    <= 1'b0;
      dac_strobe <= 1'b0;
    end else begin
      dac_strobe <= tick;
      if (tick && out_valid) begin
        dac_data <= out_q;
      end
      if (move) begin
        out_q     <= hold_q;
        out_valid <= 1'b1;
      end else if (tick) begin
        out_valid <= 1'b0;
      end
      if (dma_ack) begin
        hold_q <= dma_data;
      end
      hold_valid <= hold_nx;
      dma_req    <= !dma_ack && !stall && !hold_nx;
    end
  end
endmodule

// File: rtl/audio_irq_ctrl.sv
module audio_irq_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic mute_set,
  input  logic page_set,
  input  logic mute_clr,
  input  logic page_clr,
  output logic mute_irq,
  output logic page_irq
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mute_irq <= 1'b0;
      page_irq <= 1'b0;
    end else begin
      if (mute_set)      mute_irq <= 1'b1;
      else if (mute_clr) mute_irq <= 1'b0;
      if (page_set)      page_irq <= 1'b1;
      else if (page_clr) page_irq <= 1'b0;
    end
  end
endmodule

// File: rtl/audio_dma_out.sv
module audio_dma_out #(
  parameter int unsigned CLK_HZ     = 100_000_000,
  parameter int unsigned SETTLE_CYC = 500,
  parameter int unsigned DW         = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          out_en,
  input  logic [2:0]    rate_sel,
  input  logic          vref_on,
  output logic          dma_req,
  input  logic          dma_ack,
  input  logic [DW-1:0] dma_data,
  input  logic          dma_page_end,
  input  logic          mute_clr,
  input  logic          page_clr,
  output logic [DW-1:0] dac_data,
  output logic          dac_strobe,
  output logic          hold_valid,
  output logic          out_valid,
  output logic          mute_irq,
  output logic          page_irq
);
  logic tick;
  logic underrun;
  logic ack_ok;

  assign ack_ok = dma_ack && out_en;

  audio_tick_gen #(.CLK_HZ(CLK_HZ), .SETTLE_CYC(SETTLE_CYC)) tick_i (
    .clk(clk), .rst(rst), .out_en(out_en), .vref_on(vref_on),
    .rate_sel(rate_sel), .tick(tick)
  );

  audio_sample_pipe #(.DW(DW)) pipe_i (
    .clk(clk), .rst(rst), .out_en(out_en), .tick(tick), .stall(page_irq),
    .dma_ack(ack_ok), .dma_data(dma_data), .dma_req(dma_req),
    .hold_valid(hold_valid), .out_valid(out_valid), .dac_data(dac_data),
    .dac_strobe(dac_strobe), .underrun(underrun)
  );

  audio_irq_ctrl irq_i (
    .clk(clk), .rst(rst), .mute_set(underrun),
    .page_set(ack_ok && dma_page_end), .mute_clr(mute_clr),
    .page_clr(page_clr), .mute_irq(mute_irq), .page_irq(page_irq)
  );
endmodule

// File: rtl/audio_dma_out_chk.sv
module audio_dma_out_chk #(
  parameter int unsigned DW = 10
) (
  input logic          clk,
  input logic          rst,
  input logic          out_en,
  input logic          dma_req,
  input logic          dma_ack,
  input logic          dma_page_end,
  input logic          mute_clr,
  input logic          page_clr,
  input logic [DW-1:0] dac_data,
  input logic          dac_strobe,
  input logic          hold_valid,
  input logic          out_valid,
  input logic          mute_irq,
  input logic          page_irq
);
  a_r4_req_drops_after_ack: assert property (@(posedge clk) disable iff (rst)
    dma_ack |=> !dma_req);

  a_r10_disable_clears: assert property (@(posedge clk) disable iff (rst)
    !out_en |=> (!dma_req && !hold_valid && !out_valid && !dac_strobe));

  a_r7_underrun_mutes: assert property (@(posedge clk) disable iff (rst)
    (dac_strobe && !$past(out_valid)) |-> mute_irq);

  a_r7_underrun_holds: assert property (@(posedge clk) disable iff (rst)
    (dac_strobe && !$past(out_valid)) |-> $stable(dac_data));

  a_r8_no_req_in_page_stall: assert property (@(posedge clk) disable iff (rst)
    page_irq |-> !dma_req);

  a_r8_page_sets: assert property (@(posedge clk) disable iff (rst)
    (dma_ack && dma_page_end && out_en) |=> page_irq);

  a_r9_mute_clear: assert property (@(posedge clk) disable iff (rst)
    (mute_clr && !(dac_strobe === 1'bx) && mute_irq && !out_en) |=> !mute_irq);

  a_r9_page_clear: assert property (@(posedge clk) disable iff (rst)
    (page_clr && !(dma_ack && dma_page_end)) |=> !page_irq);
endmodule

bind audio_dma_out audio_dma_out_chk #(.DW(DW)) chk_i (
  .clk(clk), .rst(rst), .out_en(out_en), .dma_req(dma_req), .dma_ack(dma_ack),
  .dma_page_end(dma_page_end), .mute_clr(mute_clr), .page_clr(page_clr),
  .dac_data(dac_data), .dac_strobe(dac_strobe), .hold_valid(hold_valid),
  .out_valid(out_valid), .mute_irq(mute_irq), .page_irq(page_irq)
);

// File: tb/audio_dma_out_tb_top.sv
module audio_dma_out_tb_top;
  localparam int unsigned CLK_HZ = 882_000;
  localparam int unsigned SETTLE = 8;
  localparam int unsigned DW     = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic out_en = 1'b0;
  logic [2:0] rate_sel = 3'd0;
  logic vref_on = 1'b0;
  logic dma_req;
  logic dma_ack = 1'b0;
  logic [DW-1:0] dma_data = '0;
  logic dma_page_end = 1'b0;
  logic mute_clr = 1'b0;
  logic page_clr = 1'b0;
  logic [DW-1:0] dac_data;
  logic dac_strobe;
  logic hold_valid;
  logic out_valid;
  logic mute_irq;
  logic page_irq;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;
  bit dma_allow = 1'b0;
  int seq = 0;
  int page_at = -1;
  logic [DW-1:0] exp_q[$];
  logic [DW-1:0] last_out = '0;

  always #5 clk = ~clk;

  audio_dma_out #(.CLK_HZ(CLK_HZ), .SETTLE_CYC(SETTLE), .DW(DW)) dut_i (
    .clk(clk), .rst(rst), .out_en(out_en), .rate_sel(rate_sel),
    .vref_on(vref_on), .dma_req(dma_req), .dma_ack(dma_ack),
    .dma_data(dma_data), .dma_page_end(dma_page_end), .mute_clr(mute_clr),
    .page_clr(page_clr), .dac_data(dac_data), .dac_strobe(dac_strobe),
    .hold_valid(hold_valid), .out_valid(out_valid), .mute_irq(mute_irq),
    .page_irq(page_irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // DMA model (driver): answers a request, pushes the expected sample.
  initial begin
    forever begin
      @(negedge clk);
      if (dma_ack) begin
        dma_ack = 1'b0;
        dma_page_end = 1'b0;
        check("R4 req low after ack", {31'd0, dma_req}, 32'd0);
      end else if (dma_req && dma_allow && out_en) begin
        dma_data = DW'(seq * 37 + 5);
        seq++;
        dma_page_end = (seq == page_at);
        dma_ack = 1'b1;
        exp_q.push_back(dma_data);
      end
    end
  end

  // Monitor: one expected item per strobe, or an underrun if none is queued.
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && dac_strobe) begin
        if (exp_q.size() > 0) begin
          last_out = exp_q.pop_front();
          check("R6 sample order", 32'(dac_data), 32'(last_out));
        end else begin
          check("R7 output held", 32'(dac_data), 32'(last_out));
          check("R7 mute raised", {31'd0, mute_irq}, 32'd1);
          check("R7 req kept", {31'd0, dma_req}, {31'd0, !page_irq});
        end
      end
    end
  end

  task automatic wait_strobe(output int n);
    n = 0;
    do begin
      @(posedge clk);
      n++;
      @(negedge clk);
    end while (!dac_strobe && n < 2000);
  endtask

  task automatic measure(input logic [2:0] sel, input int exp_div, input string req);
    int n;
    rate_sel = sel;
    wait_strobe(n);
    wait_strobe(n);
    wait_strobe(n);
    check(req, 32'(n), 32'(exp_div));
  endtask

  task automatic pulse_clr(input bit which_page);
    @(negedge clk);
    if (which_page) page_clr = 1'b1; else mute_clr = 1'b1;
    @(negedge clk);
    page_clr = 1'b0;
    mute_clr = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int n;
    bit seen;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 dma_req", {31'd0, dma_req}, 32'd0);
    check("R1 valid flags", {30'd0, hold_valid, out_valid}, 32'd0);
    check("R1 irqs", {30'd0, mute_irq, page_irq}, 32'd0);
    check("R1 dac", {21'd0, dac_data, dac_strobe}, 32'd0);

    // R3 settling delay and R5 prefetch
    dma_allow = 1'b1;
    vref_on = 1'b1;
    out_en = 1'b1;
    n = 0;
    do begin
      @(posedge clk);
      n++;
      @(negedge clk);
      if (n == 15) begin
        check("R5 both valid", {30'd0, hold_valid, out_valid}, 32'd3);
        check("R5 req idle", {31'd0, dma_req}, 32'd0);
      end
    end while (!dac_strobe && n < 2000);
    check("R3 first strobe in window",
          {31'd0, (n >= int'(SETTLE + 19)) && (n <= int'(SETTLE + 21))}, 32'd1);

    // R2 periods per rate code
    measure(3'd0, 20, "R2 rate 0");
    measure(3'd1, 40, "R2 rate 1");
    measure(3'd2, 80, "R2 rate 2");
    measure(3'd3, 110, "R2 rate 3");
    measure(3'd5, 110, "R2 rate 5");
    rate_sel = 3'd0;
    wait_strobe(n);

    // R7 underrun: block DMA, the pipe drains over two ticks
    dma_allow = 1'b0;
    repeat (4) wait_strobe(n);
    check("R7 mute set", {31'd0, mute_irq}, 32'd1);
    dma_allow = 1'b1;
    repeat (6) @(negedge clk);
    // R9 mute clear
    pulse_clr(1'b0);
    check("R9 mute cleared", {31'd0, mute_irq}, 32'd0);
    wait_strobe(n);
    check("R9 mute stays clear", {31'd0, mute_irq}, 32'd0);

    // R8 page boundary stall
    page_at = seq + 1;
    n = 0;
    while (!page_irq && n < 500) begin
      @(negedge clk);
      n++;
    end
    check("R8 page irq set", {31'd0, page_irq}, 32'd1);
    seen = 1'b0;
    repeat (100) begin
      @(negedge clk);
      if (dma_req) seen = 1'b1;
    end
    check("R8 no req while stalled", {31'd0, seen}, 32'd0);
    pulse_clr(1'b1);
    check("R9 page cleared", {31'd0, page_irq}, 32'd0);
    seen = 1'b0;
    repeat (4) begin
      if (dma_req || dma_ack) seen = 1'b1;
      @(negedge clk);
    end
    check("R8 req resumes", {31'd0, seen}, 32'd1);
    repeat (10) @(negedge clk);
    pulse_clr(1'b0);

    // R10 disable
    dma_allow = 1'b0;
    repeat (3) @(negedge clk);
    out_en = 1'b0;
    @(negedge clk);
    exp_q.delete();
    check("R10 flags cleared", {29'd0, dma_req, hold_valid, out_valid}, 32'd0);
    seen = 1'b0;
    repeat (300) begin
      @(negedge clk);
      if (dac_strobe) seen = 1'b1;
    end
    check("R10 no strobes", {31'd0, seen}, 32'd0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule